// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block gives a host a two-address configuration window onto a 256-entry byte register file. It is meant for a legacy peripheral controller. A byte written to the lower port address sets an internal index. Accesses to the upper port address then read or write the entry that index selects. Reads at either port address return the selected entry.

Writes are filtered per entry. Most indexes are read-only and ignore data writes. Two indexes accept one specific byte only. The remaining indexes accept any byte. Entries that can never be written are built as constants, not storage.

The whole window is gated by an enable flag. That flag is cleared by reset and is loaded from one bit of a byte that a bridge writes to one configuration offset. While the window is disabled it neither claims reads nor accepts writes.

Top module: `sio_cfg_window`

## Requirements
- R1: A byte write to the index port (`io_addr` = 0x03F0) while the window is enabled loads `io_wdata` into the index register. The write takes effect at the next rising clock edge.
- R2: A read at either 0x03F0 or 0x03F1 while the window is enabled drives `io_claim` high in the same cycle. In that cycle `io_rdata` equals the entry selected by the current index.
- R3: A data-port write (0x03F1) is dropped when the index is any of these:
  - the range 0x00–0xDF;
  - 0xE4 or 0xE5;
  - the range 0xE9–0xED;
  - 0xF3, 0xF5 or 0xF7;
  - the range 0xF9–0xFB;
  - the range 0xFD–0xFF.
- R4: Entry 0xE7 takes a data-port write only when the byte is 0xFE. Any other byte leaves it unchanged.
- R5: Entry 0xE8 takes a data-port write only when the byte is 0xBE. Any other byte leaves it unchanged.
- R6: Entries 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC take any byte written to the data port.
- R7: After reset the index is 0x00. The non-zero entries are 0xE0 = 0x3C, 0xE2 = 0x03, 0xE3 = 0xFC, 0xE6 = 0xDE, 0xE7 = 0xFE and 0xE8 = 0xBE. Every other entry is 0x00.
- R8: The window is disabled after reset. A bridge write (`brg_wr`) to offset 0x85 sets the enable flag to bit 1 of `brg_wdata`. Bridge writes to any other offset leave the flag unchanged.
- R9: While the window is disabled, reads are not claimed and `io_rdata` is 0x00. Index and data writes are ignored. A host access is judged by the enable state held before that clock edge, so an access in the same cycle as a bridge write uses the old state.
- R10: Host accesses at any address other than 0x03F0 and 0x03F1 are ignored. Such reads are not claimed.
- R11: `io_rdata` is 0x00 in every cycle where `io_claim` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host byte write strobe |
| io_rd | input | 1 | Host byte read strobe |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte, 0x00 when not claimed |
| io_claim | output | 1 | Read is answered by this window |
| brg_wr | input | 1 | Bridge configuration write strobe |
| brg_off | input | 8 | Bridge configuration offset |
| brg_wdata | input | 8 | Bridge configuration write byte |

## Verification
The enable update and a host access can land on the same clock edge. The bench provokes this in two ways. First, it drives a bridge write that clears the enable bit in the very cycle of a host data write. Second, it drives a bridge write that sets the enable bit in the cycle of a host write made while the window is still disabled. After each, it re-enables the window and reads the entry back. The first write must have landed and the second must have been dropped, because each host access is judged by the enable state from before that edge.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
package sio_cfg_pkg;

  localparam int unsigned CFG_DW  = 8;
  localparam int unsigned CFG_IW  = 8;
  localparam int unsigned CFG_NUM = 1 << CFG_IW;

  typedef logic [CFG_DW-1:0] cfg_byte_t;
  typedef logic [CFG_IW-1:0] cfg_idx_t;

  // Entries that never accept a data-port write.
  function automatic bit cfg_is_locked(input cfg_idx_t idx);
    return idx inside {[8'h00:8'hDF], 8'hE4, 8'hE5, [8'hE9:8'hED],
                       8'hF3, 8'hF5, 8'hF7, [8'hF9:8'hFB], [8'hFD:8'hFF]};
  endfunction

  // Entries that accept only one specific byte.
  function automatic bit cfg_is_keyed(input cfg_idx_t idx);
    return (idx == 8'hE7) || (idx == 8'hE8);
  endfunction

  function automatic cfg_byte_t cfg_key(input cfg_idx_t idx);
    case (idx)
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic cfg_byte_t cfg_rst_val(input cfg_idx_t idx);
    case (idx)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/sio_cfg_enable.sv
`timescale 1ns/1ps
module sio_cfg_enable #(
  parameter int unsigned         OFF_W   = 8,
  parameter logic [OFF_W-1:0]    CTL_OFF = 8'h85,
  parameter int unsigned         CTL_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             brg_wr,
  input  logic [OFF_W-1:0] brg_off,
  input  logic [7:0]       brg_wdata,
  output logic             win_en
);

  logic en_q;
  logic en_d;
  logic en_load;

  always_comb begin
    en_load = brg_wr && (brg_off == CTL_OFF);
    en_d    = en_load ? brg_wdata[CTL_BIT] : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_load) begin
      en_q <= en_d;
    end
  end

  assign win_en = en_q;

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (brg_wr && brg_off == CTL_OFF) |=> (win_en == $past(brg_wdata[CTL_BIT]))); // R8
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(brg_wr && brg_off == CTL_OFF) |=> $stable(win_en)); // R8

endmodule

// File: rtl/sio_cfg_decode.sv
`timescale 1ns/1ps
module sio_cfg_decode #(
  parameter int unsigned          AW   = 16,
  parameter logic [AW-1:0]        BASE = 16'h03F0
) (
  input  logic          win_en,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  output logic          idx_wr,
  output logic          dat_wr,
  output logic          rd_hit
);

  localparam logic [AW-1:0] DATA_ADDR = BASE + AW'(1);

  logic at_idx;
  logic at_dat;

  always_comb begin
    at_idx = (io_addr == BASE);
    at_dat = (io_addr == DATA_ADDR);
    idx_wr = win_en && io_wr && at_idx;
    dat_wr = win_en && io_wr && at_dat;
    rd_hit = win_en && io_rd && (at_idx || at_dat);
  end

endmodule

// File: rtl/sio_cfg_index.sv
`timescale 1ns/1ps
module sio_cfg_index
  import sio_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      win_en,
  input  logic      idx_wr,
  input  cfg_byte_t wdata,
  output cfg_idx_t  idx
);

  cfg_idx_t idx_q;
  cfg_idx_t idx_d;

  always_comb begin
    idx_d = idx_wr ? cfg_idx_t'(wdata) : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_wr) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

  AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |=> $stable(idx)); // R9
  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx == $past(wdata))); // R1

endmodule

// File: rtl/sio_cfg_file.sv
`timescale 1ns/1ps
module sio_cfg_file
  import sio_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  cfg_idx_t  wr_idx,
  input  cfg_byte_t wr_data,
  input  cfg_idx_t  rd_idx,
  output cfg_byte_t rd_data
);

  cfg_byte_t ent [CFG_NUM];

  for (genvar g = 0; g < CFG_NUM; g++) begin : g_ent
    localparam cfg_idx_t  IDX    = cfg_idx_t'(g);
    localparam bit        LOCKED = cfg_is_locked(IDX);
    localparam bit        KEYED  = cfg_is_keyed(IDX);
    localparam cfg_byte_t KEY    = cfg_key(IDX);
    localparam cfg_byte_t RSTV   = cfg_rst_val(IDX);

    if (LOCKED) begin : g_const
      assign ent[g] = RSTV;
    end else begin : g_reg
      cfg_byte_t q;
      cfg_byte_t d;
      logic      we;

      always_comb begin
        we = wr_en && (wr_idx == IDX);
        if (KEYED) begin
          we = we && (wr_data == KEY);
        end
        d = we ? wr_data : q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= RSTV;
        end else if (we) begin
          q <= d;
        end
      end

      assign ent[g] = q;
    end
  end

  assign rd_data = ent[rd_idx];

  cfg_byte_t ent_e7;
  cfg_byte_t ent_e8;
  assign ent_e7 = ent[8'hE7];
  assign ent_e8 = ent[8'hE8];

  AST_E7_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 8'hE7 && wr_data != 8'hFE) |=> $stable(ent_e7)); // R4
  AST_E8_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 8'hE8 && wr_data != 8'hBE) |=> $stable(ent_e8)); // R5
  AST_E0_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 8'hE0) |=> (ent[8'hE0] == $past(wr_data))); // R6

endmodule

// File: rtl/sio_cfg_window.sv
`timescale 1ns/1ps
module sio_cfg_window
  import sio_cfg_pkg::*;
#(
  parameter int unsigned          AW      = 16,
  parameter logic [AW-1:0]        BASE    = 16'h03F0,
  parameter int unsigned          OFF_W   = 8,
  parameter logic [OFF_W-1:0]     CTL_OFF = 8'h85,
  parameter int unsigned          CTL_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic             io_claim,
  input  logic             brg_wr,
  input  logic [OFF_W-1:0] brg_off,
  input  logic [7:0]       brg_wdata
);

  logic      win_en;
  logic      idx_wr;
  logic      dat_wr;
  logic      rd_hit;
  cfg_idx_t  cur_idx;
  cfg_byte_t file_rd;

  sio_cfg_enable #(
    .OFF_W   (OFF_W),
    .CTL_OFF (CTL_OFF),
    .CTL_BIT (CTL_BIT)
  ) i_enable (
    .clk       (clk),
    .rst_n     (rst_n),
    .brg_wr    (brg_wr),
    .brg_off   (brg_off),
    .brg_wdata (brg_wdata),
    .win_en    (win_en)
  );

  sio_cfg_decode #(
    .AW   (AW),
    .BASE (BASE)
  ) i_decode (
    .win_en  (win_en),
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .idx_wr  (idx_wr),
    .dat_wr  (dat_wr),
    .rd_hit  (rd_hit)
  );

  sio_cfg_index i_index (
    .clk    (clk),
    .rst_n  (rst_n),
    .win_en (win_en),
    .idx_wr (idx_wr),
    .wdata  (io_wdata),
    .idx    (cur_idx)
  );

  sio_cfg_file i_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dat_wr),
    .wr_idx  (cur_idx),
    .wr_data (io_wdata),
    .rd_idx  (cur_idx),
    .rd_data (file_rd)
  );

  always_comb begin
    io_claim = rd_hit;
    io_rdata = rd_hit ? file_rd : 8'h00;
  end

  AST_CLAIM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    io_claim |-> (win_en && io_rd)); // R9
  AST_CLAIM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    io_claim |-> (io_addr == BASE || io_addr == BASE + AW'(1))); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !io_claim |-> (io_rdata == 8'h00)); // R11
  AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_en && io_rd && io_addr == BASE + AW'(1)) |-> !io_claim); // R9

endmodule

// File: tb/test_sio_cfg_window.sv
`timescale 1ns/1ps
module test_sio_cfg_window;

  localparam logic [15:0] P_IDX = 16'h03F0;
  localparam logic [15:0] P_DAT = 16'h03F1;

  logic        clk;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        io_claim;
  logic        brg_wr;
  logic [7:0]  brg_off;
  logic [7:0]  brg_wdata;

  int errors;
  int checks;
  bit done;
  logic [7:0] mdl [256];

  sio_cfg_window i_sio_cfg_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .io_claim  (io_claim),
    .brg_wr    (brg_wr),
    .brg_off   (brg_off),
    .brg_wdata (brg_wdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic bit tb_locked(input int i);
    return (i <= 223) || (i == 228) || (i == 229) || (i >= 233 && i <= 237) ||
           (i == 243) || (i == 245) || (i == 247) || (i >= 249 && i <= 251) ||
           (i >= 253);
  endfunction

  function automatic logic [7:0] tb_rst(input int i);
    if (i == 224) return 8'h3C;
    if (i == 226) return 8'h03;
    if (i == 227) return 8'hFC;
    if (i == 230) return 8'hDE;
    if (i == 231) return 8'hFE;
    if (i == 232) return 8'hBE;
    return 8'h00;
  endfunction

  function automatic void tb_model_wr(input int i, input logic [7:0] v);
    if (tb_locked(i)) return;
    if (i == 231 && v != 8'hFE) return;
    if (i == 232 && v != 8'hBE) return;
    mdl[i] = v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic c, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1;
    c = io_claim; d = io_rdata;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic brg_write(input logic [7:0] o, input logic [7:0] d);
    @(negedge clk);
    brg_off = o; brg_wdata = d; brg_wr = 1'b1;
    @(negedge clk);
    brg_wr = 1'b0;
  endtask

  task automatic both_write(input logic [7:0] bd, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    brg_off = 8'h85; brg_wdata = bd; brg_wr = 1'b1;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    brg_wr = 1'b0; io_wr = 1'b0;
  endtask

  initial begin
    logic       c;
    logic [7:0] d;
    errors = 0; checks = 0; done = 1'b0;
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    brg_wr = 1'b0; brg_off = '0; brg_wdata = '0;
    for (int i = 0; i < 256; i++) mdl[i] = tb_rst(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8: disabled out of reset
    io_read(P_DAT, c, d);
    chk(c == 1'b0, "R8 claim after reset", c, 0);
    chk(d == 8'h00, "R11 rdata idle", d, 0);
    brg_write(8'h84, 8'h02);
    io_read(P_DAT, c, d);
    chk(c == 1'b0, "R8 other offset ignored", c, 0);
    brg_write(8'h85, 8'h02);
    // R7: index is 0x00 after reset, entry 0 reads 0
    io_read(P_DAT, c, d);
    chk(c == 1'b1, "R8 enabled by bit1", c, 1);
    chk(d == 8'h00, "R7 index 0 entry", d, 0);

    // R7/R2: reset value sweep, read through the index address
    for (int i = 0; i < 256; i++) begin
      io_write(P_IDX, 8'(i));
      io_read(P_IDX, c, d);
      chk(c == 1'b1 && d == mdl[i], "R7 R2 reset value", {c, d}, {1'b1, mdl[i]});
    end

    // R1/R3/R6/R4/R5: write sweep with an index-dependent pattern
    for (int i = 0; i < 256; i++) begin
      logic [7:0] pat;
      pat = 8'((i * 7 + 3) & 255);
      io_write(P_IDX, 8'(i));
      io_write(P_DAT, pat);
      tb_model_wr(i, pat);
      io_read(P_DAT, c, d);
      chk(d == mdl[i], tb_locked(i) ? "R3 locked entry" : "R6 R1 write entry", d, mdl[i]);
    end

    // R4: key entry 0xE7
    io_write(P_IDX, 8'hE7);
    io_write(P_DAT, 8'hFF); tb_model_wr(231, 8'hFF);
    io_read(P_DAT, c, d);
    chk(d == 8'hFE, "R4 wrong key dropped", d, 8'hFE);
    io_write(P_DAT, 8'hFE); tb_model_wr(231, 8'hFE);
    io_read(P_DAT, c, d);
    chk(d == 8'hFE, "R4 key accepted", d, 8'hFE);
    // R5: key entry 0xE8
    io_write(P_IDX, 8'hE8);
    io_write(P_DAT, 8'hBF); tb_model_wr(232, 8'hBF);
    io_read(P_DAT, c, d);
    chk(d == 8'hBE, "R5 wrong key dropped", d, 8'hBE);
    io_write(P_DAT, 8'h00); tb_model_wr(232, 8'h00);
    io_read(P_DAT, c, d);
    chk(d == 8'hBE, "R5 zero dropped", d, 8'hBE);

    // R9: disabled window ignores everything
    io_write(P_IDX, 8'hE0);
    io_write(P_DAT, 8'h11); tb_model_wr(224, 8'h11);
    brg_write(8'h85, 8'hFD);
    io_read(P_IDX, c, d);
    chk(c == 1'b0 && d == 8'h00, "R9 no claim when disabled", {c, d}, 0);
    io_write(P_IDX, 8'hF0);
    io_write(P_DAT, 8'h99);
    brg_write(8'h85, 8'h02);
    io_read(P_DAT, c, d);
    chk(c == 1'b1 && d == 8'h11, "R9 index and entry kept", {c, d}, {1'b1, 8'h11});
    io_write(P_IDX, 8'hF0);
    io_read(P_DAT, c, d);
    chk(d == mdl[240], "R9 F0 untouched", d, mdl[240]);

    // R10: foreign addresses
    io_write(P_IDX, 8'hE0);
    io_write(16'h03F2, 8'hE2);
    io_write(16'h13F0, 8'hE3);
    io_write(16'h13F1, 8'h55);
    io_read(P_DAT, c, d);
    chk(d == 8'h11, "R10 foreign writes ignored", d, 8'h11);
    io_read(16'h03F2, c, d);
    chk(c == 1'b0 && d == 8'h00, "R10 foreign read unclaimed", {c, d}, 0);

    // R9: bridge disable and host write in the same cycle, write lands
    io_write(P_IDX, 8'hE2);
    both_write(8'h00, P_DAT, 8'h77); tb_model_wr(226, 8'h77);
    io_read(P_DAT, c, d);
    chk(c == 1'b0, "R9 disabled after same-cycle write", c, 0);
    // R9: bridge enable and host write in the same cycle, write dropped
    both_write(8'h02, P_DAT, 8'h33);
    io_read(P_DAT, c, d);
    chk(c == 1'b1 && d == 8'h77, "R9 old enable state used", {c, d}, {1'b1, 8'h77});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule